// File: doc/BRIEF.md
# Embedded-Clock Word Serializer

This block turns a parallel word, captured from a word clock, into a serial stream of fixed-length symbols. Each symbol wraps the word between a high start bit and a low stop bit, so every symbol has a rising edge at its front that a receiver can recover a clock from. The shift advances on a bit-rate enable that runs at twelve times the word rate for the default ten-bit word. The word clock is sampled by the system clock. A select input chooses whether its rising or its falling edge captures the data.

Two sync request inputs make the block send a training symbol instead of data. The training symbol is a run of ones for the first half of the symbol and a run of zeros for the second half. An output enable and an active-low powerdown input control the line. The high-impedance state of the line is represented by a drive-enable flag, and the serial bit is held at 0 whenever that flag is low. Lock of the internal clock generator is modelled as a count of word-clock rising edges. State changes happen only where one symbol ends and the next begins.

Top module: `ser_embedded_clk`

## Requirements
- R1: Each symbol is DW+2 bits, one per bit enable: bit 0 is the start bit and is 1, bits 1..DW are the word with its LSB first, and bit DW+1 is the stop bit and is 0.
- R2: With `cap_rise_sel` = 1 the word is captured on a rising edge of `word_clk`; with 0 it is captured on a falling edge.
- R3: If `sync_req_a` or `sync_req_b` is high at a symbol boundary, the next symbol is the training pattern: bits 0..5 are 1 and bits 6..11 are 0.
- R4: The training pattern stops, and data resumes, at the first symbol boundary at which both sync requests are low.
- R5: Once sync has been requested for SYNC_HOLD (5) word-clock rising edges, data capture is frozen until data sending resumes. The first data symbol after sync then carries the last word captured before the freeze.
- R6: `ser_oe` is high only while sending data or training symbols with `line_en` high and `pwr_on` high; `ser_out` is 0 whenever `ser_oe` is low.
- R7: `line_en` low drops `ser_oe` at the next boundary. Raising it again resumes the same kind of symbol (data or training) without a new lock.
- R8: `pwr_on` low drops `ser_oe` at the next boundary and clears lock. After release, `ser_oe` stays low until LOCK_WCYC (8) new word-clock rising edges have been counted.
- R9: After reset `ser_oe` and `ser_out` are 0, and `ser_oe` stays 0 until LOCK_WCYC word-clock rising edges have been seen.
- R10: `ser_oe` changes only at symbol boundaries, so the line never carries a partial symbol.
- R11: Words presented while the block is powered down or waiting for lock are discarded. The first data symbol after relock carries the word captured before powerdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Bit-rate enable, one pulse per serial bit |
| word_clk | input | 1 | Word clock, sampled by `clk` |
| cap_rise_sel | input | 1 | 1 captures on a rising word-clock edge, 0 on a falling edge |
| din | input | DW | Parallel data word |
| sync_req_a | input | 1 | Sync request, first input |
| sync_req_b | input | 1 | Sync request, second input |
| line_en | input | 1 | Output enable; low sets the line to high impedance |
| pwr_on | input | 1 | Active-low powerdown (high = running) |
| ser_out | output | 1 | Serial bit |
| ser_oe | output | 1 | Line drive enable (low = high impedance) |

## Verification
A symbol boundary updates `ser_oe` and the shift register on the same edge. The bench therefore aligns on the first cycle in which `ser_oe` reads high and takes one sample per clock for twelve clocks. Control inputs are driven on the falling edge right after a symbol finishes, so they are seen at the very next boundary. Checks on `ser_oe` are made a few cycles after that boundary. A captured word reaches the line one boundary after its capturing edge. The phase between the word clock and the symbol is free, so data checks look at least two symbols after a new word, except where R5 and R11 fix the first symbol exactly. Lock checks sample well inside the eight-word-period window.

// File: rtl/ser_pkg.sv
package ser_pkg;
  typedef enum logic [1:0] {
    ST_INIT  = 2'd0,
    ST_SYNC  = 2'd1,
    ST_DATA  = 2'd2,
    ST_PDOWN = 2'd3
  } ser_state_e;
endpackage

// File: rtl/ser_wclk_capture.sv
module ser_wclk_capture #(
  parameter int DW        = 10,
  parameter int SYNC_HOLD = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          word_clk,
  input  logic          cap_rise_sel,
  input  logic [DW-1:0] din,
  input  logic          sync_any,
  input  logic          in_sync_state,
  input  logic          cap_allow,
  output logic          wclk_rise,
  output logic          cap_suppress,
  output logic [DW-1:0] hold_word
);
  localparam int CW = $clog2(SYNC_HOLD + 1);
  localparam logic [CW-1:0] HOLD_LIM = CW'(SYNC_HOLD);

  logic          wc_q, wc_qq;
  logic [DW-1:0] din_q;
  logic [CW-1:0] sync_cnt;
  logic          wclk_fall, cap_edge, cap_fire;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wc_q  <= 1'b0;
      wc_qq <= 1'b0;
      din_q <= '0;
    end else begin
      wc_q  <= word_clk;
      wc_qq <= wc_q;
      din_q <= din;
    end
  end

  assign wclk_rise = wc_q & ~wc_qq;
  assign wclk_fall = ~wc_q & wc_qq;
  assign cap_edge  = cap_rise_sel ? wclk_rise : wclk_fall;

  // sync request length in word-clock rising edges, saturating
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_cnt <= '0;
    end else if (!sync_any && !in_sync_state) begin
      sync_cnt <= '0;
    end else if (sync_any && wclk_rise && sync_cnt != HOLD_LIM) begin
      sync_cnt <= sync_cnt + CW'(1);
    end
  end

  assign cap_suppress = (sync_cnt == HOLD_LIM) && in_sync_state;
  assign cap_fire     = cap_edge && cap_allow && !cap_suppress;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_word <= '0;
    end else if (cap_fire) begin
      hold_word <= din_q;
    end
  end

  assert_hold_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cap_suppress |=> $stable(hold_word));

  assert_discard_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_allow |=> $stable(hold_word));
endmodule

// File: rtl/ser_lock_model.sv
module ser_lock_model #(
  parameter int LOCK_WCYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic wclk_rise,
  output logic locked
);
  localparam int LW = $clog2(LOCK_WCYC + 1);
  localparam logic [LW-1:0] LOCK_LIM = LW'(LOCK_WCYC);

  logic [LW-1:0] lock_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      lock_cnt <= '0;
    end else if (wclk_rise && !locked) begin
      lock_cnt <= lock_cnt + LW'(1);
    end
  end

  assign locked = (lock_cnt == LOCK_LIM);

  assert_lock_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !locked);
endmodule

// File: rtl/ser_symbol_shifter.sv
module ser_symbol_shifter #(
  parameter int SW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_en,
  input  logic [SW-1:0] load_word,
  output logic          sym_end,
  output logic          first_bit,
  output logic          last_bit,
  output logic          line_bit
);
  localparam int IW = $clog2(SW);
  localparam logic [IW-1:0] LAST_IDX = IW'(SW - 1);

  logic [IW-1:0] bit_idx;
  logic [SW-1:0] shreg;

  assign first_bit = (bit_idx == '0);
  assign last_bit  = (bit_idx == LAST_IDX);
  assign sym_end   = bit_en && last_bit;
  assign line_bit  = shreg[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_idx <= LAST_IDX;
      shreg   <= '0;
    end else if (sym_end) begin
      bit_idx <= '0;
      shreg   <= load_word;
    end else if (bit_en) begin
      bit_idx <= bit_idx + IW'(1);
      shreg   <= {1'b0, shreg[SW-1:1]};
    end
  end

  assert_wrap_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sym_end |=> first_bit);
endmodule

// File: rtl/ser_embedded_clk.sv
module ser_embedded_clk
  import ser_pkg::*;
#(
  parameter int DW        = 10,
  parameter int LOCK_WCYC = 8,
  parameter int SYNC_HOLD = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_en,
  input  logic          word_clk,
  input  logic          cap_rise_sel,
  input  logic [DW-1:0] din,
  input  logic          sync_req_a,
  input  logic          sync_req_b,
  input  logic          line_en,
  input  logic          pwr_on,
  output logic          ser_out,
  output logic          ser_oe
);
  localparam int SW   = DW + 2;
  localparam int HALF = SW / 2;

  function automatic logic [SW-1:0] frame_word(input logic [DW-1:0] w);
    return {1'b0, w, 1'b1};
  endfunction

  function automatic logic [SW-1:0] train_symbol();
    logic [SW-1:0] t;
    for (int i = 0; i < SW; i++) t[i] = (i < HALF);
    return t;
  endfunction

  ser_state_e    st_q, st_nxt;
  logic          oe_q;
  logic          sync_any, sending, cap_allow, lock_run, lock_ok;
  logic          wclk_rise, cap_suppress;
  logic [DW-1:0] hold_word;
  logic          sym_end, first_bit, last_bit, line_bit;
  logic [SW-1:0] load_word;

  assign sync_any  = sync_req_a | sync_req_b;
  assign sending   = (st_q == ST_DATA) || (st_q == ST_SYNC);
  assign cap_allow = sending;
  assign lock_run  = pwr_on && (st_q != ST_PDOWN);

  ser_wclk_capture #(.DW(DW), .SYNC_HOLD(SYNC_HOLD)) u_cap (
    .clk          (clk),
    .rst_n        (rst_n),
    .word_clk     (word_clk),
    .cap_rise_sel (cap_rise_sel),
    .din          (din),
    .sync_any     (sync_any),
    .in_sync_state(st_q == ST_SYNC),
    .cap_allow    (cap_allow),
    .wclk_rise    (wclk_rise),
    .cap_suppress (cap_suppress),
    .hold_word    (hold_word)
  );

  ser_lock_model #(.LOCK_WCYC(LOCK_WCYC)) u_lock (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (lock_run),
    .wclk_rise (wclk_rise),
    .locked    (lock_ok)
  );

  ser_symbol_shifter #(.SW(SW)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_en    (bit_en),
    .load_word (load_word),
    .sym_end   (sym_end),
    .first_bit (first_bit),
    .last_bit  (last_bit),
    .line_bit  (line_bit)
  );

  always_comb begin
    st_nxt = st_q;
    if (!pwr_on) begin
      st_nxt = ST_PDOWN;
    end else begin
      unique case (st_q)
        ST_PDOWN: st_nxt = ST_INIT;
        ST_INIT:  st_nxt = lock_ok ? (sync_any ? ST_SYNC : ST_DATA) : ST_INIT;
        default:  st_nxt = sync_any ? ST_SYNC : ST_DATA;
      endcase
    end
  end

  assign load_word = (st_nxt == ST_SYNC) ? train_symbol() : frame_word(hold_word);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= ST_INIT;
      oe_q <= 1'b0;
    end else if (sym_end) begin
      st_q <= st_nxt;
      oe_q <= line_en && ((st_nxt == ST_DATA) || (st_nxt == ST_SYNC));
    end
  end

  assign ser_oe  = oe_q;
  assign ser_out = oe_q & line_bit;

  assert_oe_boundary_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_oe != $past(ser_oe)) |-> $past(sym_end));

  assert_quiet_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_oe |-> !ser_out);

  assert_oe_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ser_oe |-> sending);

  assert_start_bit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_oe && first_bit) |-> ser_out);

  assert_stop_bit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_oe && last_bit) |-> !ser_out);

  assert_lock_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ser_oe) && $past(st_q == ST_INIT)) |-> $past(lock_ok));
endmodule

// File: tb/ser_embedded_clk_test.sv
module ser_embedded_clk_test;
  localparam int DW = 10;
  localparam int SW = DW + 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bit_en = 1'b1;
  logic          word_clk = 1'b0;
  logic          cap_rise_sel = 1'b1;
  logic [DW-1:0] din = 10'h2A5;
  logic          sync_req_a = 1'b0;
  logic          sync_req_b = 1'b0;
  logic          line_en = 1'b1;
  logic          pwr_on = 1'b1;
  logic          ser_out, ser_oe;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  ser_embedded_clk #(.DW(DW), .LOCK_WCYC(8), .SYNC_HOLD(5)) uut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .word_clk(word_clk),
    .cap_rise_sel(cap_rise_sel), .din(din), .sync_req_a(sync_req_a),
    .sync_req_b(sync_req_b), .line_en(line_en), .pwr_on(pwr_on),
    .ser_out(ser_out), .ser_oe(ser_oe)
  );

  // word clock: 12 system clocks per period, driven on falling edges
  int            wc_ph = 0;
  logic          alt_mode = 1'b0;
  logic [DW-1:0] alt_x = '0, alt_y = '0;
  always @(negedge clk) begin
    wc_ph = (wc_ph + 1) % 12;
    word_clk = (wc_ph < 6);
    if (alt_mode) din = (wc_ph >= 3 && wc_ph <= 8) ? alt_y : alt_x;
  end

  // symbol collector, aligned on the drive-enable rising
  event          sym_ev;
  logic [SW-1:0] cur_sym = '0, last_sym = '0;
  logic          oe_prev = 1'b0;
  int            ph = 0, oe_cnt = 0, partial = 0;
  always @(negedge clk) begin
    if (ser_oe && !oe_prev) ph = 0;
    else ph = (ph + 1) % SW;
    oe_prev = ser_oe;
    cur_sym[ph] = ser_out;
    oe_cnt = (ph == 0) ? int'(ser_oe) : oe_cnt + int'(ser_oe);
    if (ph == SW - 1) begin
      if (oe_cnt == SW) begin
        last_sym = cur_sym;
        -> sym_ev;
      end else if (oe_cnt != 0) begin
        partial++;
      end
    end
  end

  function automatic logic [SW-1:0] exp_frame(input logic [DW-1:0] w);
    logic [SW-1:0] f;
    f[0] = 1'b1;
    for (int k = 1; k <= DW; k++) f[k] = w[k-1];
    f[SW-1] = 1'b0;
    return f;
  endfunction

  localparam logic [SW-1:0] EXP_TRAIN = 12'b000000_111111;

  task automatic check(input bit ok, input string req, input logic [SW-1:0] act,
                       input logic [SW-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_syms(input int n);
    repeat (n) @(sym_ev);
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic test_reset_lock();
    cycles(3);
    check(ser_oe == 1'b0, "R9 reset oe", 12'(ser_oe), 12'h0);
    check(ser_out == 1'b0, "R6 reset line", 12'(ser_out), 12'h0);
    rst_n = 1'b1;
    cycles(60);
    check(ser_oe == 1'b0, "R9 no drive before lock", 12'(ser_oe), 12'h0);
    wait_syms(2);
    check(last_sym == exp_frame(10'h2A5), "R1 first frames", last_sym, exp_frame(10'h2A5));
  endtask

  task automatic test_frames();
    logic [DW-1:0] pats [4] = '{10'h3FF, 10'h000, 10'h155, 10'h001};
    for (int i = 0; i < 4; i++) begin
      din = pats[i];
      wait_syms(3);
      check(last_sym == exp_frame(pats[i]), "R1 framing", last_sym, exp_frame(pats[i]));
    end
  endtask

  task automatic test_edge_sel();
    alt_x = 10'h0F0;
    alt_y = 10'h30F;
    alt_mode = 1'b1;
    cap_rise_sel = 1'b1;
    wait_syms(3);
    check(last_sym == exp_frame(alt_x), "R2 rising capture", last_sym, exp_frame(alt_x));
    cap_rise_sel = 1'b0;
    wait_syms(3);
    check(last_sym == exp_frame(alt_y), "R2 falling capture", last_sym, exp_frame(alt_y));
    alt_mode = 1'b0;
    cap_rise_sel = 1'b1;
  endtask

  task automatic test_sync();
    din = 10'h123;
    wait_syms(3);
    sync_req_a = 1'b1;
    wait_syms(2);
    check(last_sym == EXP_TRAIN, "R3 train on a", last_sym, EXP_TRAIN);
    sync_req_a = 1'b0;
    sync_req_b = 1'b1;
    wait_syms(2);
    check(last_sym == EXP_TRAIN, "R3 train on b", last_sym, EXP_TRAIN);
    wait_syms(4);
    din = 10'h2DB;
    wait_syms(2);
    check(last_sym == EXP_TRAIN, "R4 train while held", last_sym, EXP_TRAIN);
    sync_req_b = 1'b0;
    wait_syms(1);
    check(last_sym == exp_frame(10'h123), "R5 frozen word first", last_sym, exp_frame(10'h123));
    wait_syms(2);
    check(last_sym == exp_frame(10'h2DB), "R4 data resumes", last_sym, exp_frame(10'h2DB));
  endtask

  task automatic test_line_en();
    din = 10'h0C3;
    wait_syms(3);
    check(last_sym == exp_frame(10'h0C3), "R1 before disable", last_sym, exp_frame(10'h0C3));
    line_en = 1'b0;
    cycles(3);
    check(ser_oe == 1'b0, "R7 disable drops oe", 12'(ser_oe), 12'h0);
    check(ser_out == 1'b0, "R6 line quiet", 12'(ser_out), 12'h0);
    cycles(30);
    check(ser_oe == 1'b0, "R7 stays off", 12'(ser_oe), 12'h0);
    line_en = 1'b1;
    wait_syms(2);
    check(last_sym == exp_frame(10'h0C3), "R7 data returns", last_sym, exp_frame(10'h0C3));
    sync_req_a = 1'b1;
    wait_syms(2);
    line_en = 1'b0;
    cycles(30);
    check(ser_oe == 1'b0, "R7 off during train", 12'(ser_oe), 12'h0);
    line_en = 1'b1;
    wait_syms(2);
    check(last_sym == EXP_TRAIN, "R7 train returns", last_sym, EXP_TRAIN);
    sync_req_a = 1'b0;
    wait_syms(3);
  endtask

  task automatic test_powerdown();
    din = 10'h1E1;
    wait_syms(3);
    check(last_sym == exp_frame(10'h1E1), "R1 before powerdown", last_sym, exp_frame(10'h1E1));
    pwr_on = 1'b0;
    cycles(3);
    check(ser_oe == 1'b0, "R8 powerdown drops oe", 12'(ser_oe), 12'h0);
    din = 10'h3C0;
    cycles(30);
    pwr_on = 1'b1;
    cycles(70);
    check(ser_oe == 1'b0, "R8 relock wait", 12'(ser_oe), 12'h0);
    wait_syms(1);
    check(last_sym == exp_frame(10'h1E1), "R11 idle word discarded", last_sym, exp_frame(10'h1E1));
    wait_syms(2);
    check(last_sym == exp_frame(10'h3C0), "R8 data after relock", last_sym, exp_frame(10'h3C0));
  endtask

  initial begin
    test_reset_lock();
    test_frames();
    test_edge_sel();
    test_sync();
    test_line_en();
    test_powerdown();
    check(partial == 0, "R10 no partial symbol", 12'(partial), 12'h0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule